// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Engine

This block performs integer multiplication and division for a processor core, one operation at a time. The caller presents an operation code and two 64-bit operands together with a start request. The unit takes the request when it is idle and then reports busy for a fixed number of cycles, which depends only on the operation type. At the end it writes two 64-bit result registers and raises a one-cycle done pulse. The high register holds the upper product half or the remainder. The low register holds the lower product half or the quotient.

Operands can be 32 or 64 bits wide and can be treated as signed or unsigned. Internally the multiplier retires several multiplier bits per cycle and the divider uses a one-bit-per-cycle restoring loop. A separate latency counter sets the moment of completion, so the timing seen by the caller never depends on the operand values. A read request for the result registers made while an operation is in flight raises a stall output, which tells the surrounding pipeline to wait.

Top module: `mdu_unit`

## Requirements
- R1: `op_i` is decoded as follows: bit 0 set selects divide (clear selects multiply), bit 1 set selects 64-bit operands (clear selects 32-bit), and bit 2 set selects signed arithmetic (clear selects unsigned). A request is taken at a rising edge where `start_i` and `ready_o` are both high. `ready_o` is low whenever `busy_o` is high.
- R2: The accepting edge is followed by exactly N clock edges before `hi_o`/`lo_o` take the new result and `done_o` goes high for one cycle. N is 10 for a 32-bit multiply, 20 for a 64-bit multiply, 69 for a 32-bit divide and 133 for a 64-bit divide. `busy_o` stays high for all N cycles.
- R3: A start request made while busy is ignored. The running operation keeps its result and its completion cycle, and no extra completion occurs.
- R4: For a multiply, `hi_o` holds the upper half and `lo_o` the lower half of the double-width product.
- R5: For a divide, `lo_o` holds the quotient rounded toward zero and `hi_o` the remainder. In signed mode the remainder has the sign of the dividend.
- R6: A divide by zero completes with normal latency. `lo_o` is then all ones and `hi_o` is the dividend (in 32-bit mode, its low 32 bits sign-extended).
- R7: A signed divide of the most negative value by minus one returns the dividend as the quotient and zero as the remainder.
- R8: In 32-bit mode only bits 31:0 of each operand are used, sign-extended when signed and zero-extended when unsigned. Both 32-bit results are sign-extended to 64 bits.
- R9: `stall_o` is high in any cycle where `busy_o` is high and `rd_hi_i` or `rd_lo_i` is high. It is low whenever the unit is idle.
- R10: After reset `hi_o` and `lo_o` are zero, `ready_o` is high, and `busy_o`, `done_o` and `stall_o` are low.
- R11: A new request may be taken in the same cycle that `done_o` is high. `hi_o`/`lo_o` keep the previous result until the new operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Operation code: divide, 64-bit, signed |
| a_i | input | 64 | Multiplicand or dividend |
| b_i | input | 64 | Multiplier or divisor |
| ready_o | output | 1 | Unit idle, request will be taken |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rd_hi_i | input | 1 | Pipeline wants to read the high result |
| rd_lo_i | input | 1 | Pipeline wants to read the low result |
| stall_o | output | 1 | Result read must wait |
| hi_o | output | 64 | Upper product half or remainder |
| lo_o | output | 64 | Lower product half or quotient |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle, because `ready_o` comes back up in the done cycle. The bench provokes this by queuing a second request right behind the first: its driver waits for `ready_o` and so raises `start_i` exactly in the done cycle. The scoreboard then judges both completions by their exact cycle and value. The bench also confirms that, while the second operation runs, the result registers still show the first result. Start requests made during busy, and result reads made during busy, are judged at the outputs by the unchanged completion cycle and by `stall_o`.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int XLEN = 64;
  localparam int HLEN = XLEN / 2;

  typedef struct packed {
    logic sgn;
    logic wide;
    logic div;
  } mdu_op_t;

  function automatic logic [XLEN-1:0] sext_half(input logic [HLEN-1:0] v);
    return {{HLEN{v[HLEN-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] widen_opnd(input logic [XLEN-1:0] v,
                                                 input logic wide,
                                                 input logic sgn);
    if (wide) return v;
    if (sgn)  return sext_half(v[HLEN-1:0]);
    return {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v,
                                                input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  // Signed fix-up of an unsigned product, then packing into {hi, lo}
  function automatic logic [2*XLEN-1:0] mul_pack(input logic [2*XLEN-1:0] mag,
                                                 input logic neg,
                                                 input logic wide);
    logic [2*XLEN-1:0] p;
    p = neg ? (~mag + 1'b1) : mag;
    if (wide) return p;
    return {sext_half(p[XLEN-1:HLEN]), sext_half(p[HLEN-1:0])};
  endfunction

  // Signed fix-up of quotient/remainder, divide-by-zero values, packing into {hi, lo}
  function automatic logic [2*XLEN-1:0] div_pack(input logic [XLEN-1:0] qmag,
                                                 input logic [XLEN-1:0] rmag,
                                                 input logic negq,
                                                 input logic negr,
                                                 input logic wide,
                                                 input logic dz,
                                                 input logic [XLEN-1:0] dvd);
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] r;
    if (dz) begin
      q = '1;
      r = dvd;
    end else begin
      q = negq ? (~qmag + 1'b1) : qmag;
      r = negr ? (~rmag + 1'b1) : rmag;
    end
    if (wide) return {r, q};
    return {sext_half(r[HLEN-1:0]), sext_half(q[HLEN-1:0])};
  endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int L_M32 = 10,
  parameter int L_M64 = 20,
  parameter int L_D32 = 69,
  parameter int L_D64 = 133,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  mdu_op_t          op_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             commit_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] lat_minus_one(input mdu_op_t o);
    case ({o.div, o.wide})
      2'b00:   return CNT_W'(L_M32 - 1);
      2'b01:   return CNT_W'(L_M64 - 1);
      2'b10:   return CNT_W'(L_D32 - 1);
      default: return CNT_W'(L_D64 - 1);
    endcase
  endfunction

  assign accept_o = start_i & ~busy_q;
  assign commit_o = busy_q & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= commit_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_minus_one(op_i);
      end else if (commit_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/mdu_mul_engine.sv
module mdu_mul_engine
  import mdu_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [XLEN-1:0]   a_mag_i,
  input  logic [XLEN-1:0]   b_mag_i,
  output logic [2*XLEN-1:0] prod_o,
  output logic              fin_o
);

  localparam int STEPS_W   = $clog2(XLEN / DIGIT_W) + 1;
  localparam int STEPS_64  = XLEN / DIGIT_W;
  localparam int STEPS_32  = HLEN / DIGIT_W;

  logic [2*XLEN-1:0] acc_q;
  logic [2*XLEN-1:0] mcand_q;
  logic [XLEN-1:0]   mplier_q;
  logic [STEPS_W-1:0] left_q;
  logic [2*XLEN-1:0] partial;

  // Partial product for one multiplier digit: one shifted addend per digit bit
  always_comb begin
    partial = '0;
    for (int j = 0; j < DIGIT_W; j++) begin
      if (mplier_q[j]) partial = partial + (mcand_q << j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      left_q   <= '0;
    end else if (load_i) begin
      acc_q    <= '0;
      mcand_q  <= {{XLEN{1'b0}}, a_mag_i};
      mplier_q <= b_mag_i;
      left_q   <= wide_i ? STEPS_W'(STEPS_64) : STEPS_W'(STEPS_32);
    end else if (left_q != '0) begin
      acc_q    <= acc_q + partial;
      mcand_q  <= mcand_q << DIGIT_W;
      mplier_q <= mplier_q >> DIGIT_W;
      left_q   <= left_q - 1'b1;
    end
  end

  assign prod_o = acc_q;
  assign fin_o  = (left_q == '0);

endmodule

// File: rtl/mdu_div_engine.sv
module mdu_div_engine
  import mdu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dvd_mag_i,
  input  logic [XLEN-1:0] dvs_mag_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o,
  output logic            fin_o
);

  localparam int STEPS_W = $clog2(XLEN) + 1;

  logic [XLEN-1:0]    dvd_q;
  logic [XLEN-1:0]    dvs_q;
  logic [XLEN-1:0]    quo_q;
  logic [XLEN-1:0]    rem_q;
  logic [STEPS_W-1:0] left_q;
  logic [XLEN:0]      shifted;
  logic [XLEN:0]      trial;
  logic               borrow;

  // One restoring step: bring down the next dividend bit, try to subtract
  always_comb begin
    shifted = {rem_q, dvd_q[XLEN-1]};
    trial   = shifted - {1'b0, dvs_q};
    borrow  = trial[XLEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      dvd_q  <= wide_i ? dvd_mag_i : {dvd_mag_i[HLEN-1:0], {HLEN{1'b0}}};
      dvs_q  <= dvs_mag_i;
      quo_q  <= '0;
      rem_q  <= '0;
      left_q <= wide_i ? STEPS_W'(XLEN) : STEPS_W'(HLEN);
    end else if (left_q != '0) begin
      dvd_q  <= dvd_q << 1;
      quo_q  <= {quo_q[XLEN-2:0], ~borrow};
      rem_q  <= borrow ? shifted[XLEN-1:0] : trial[XLEN-1:0];
      left_q <= left_q - 1'b1;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign fin_o = (left_q == '0);

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int L_M32   = 10,
  parameter int L_M64   = 20,
  parameter int L_D32   = 69,
  parameter int L_D64   = 133
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  op_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  output logic        ready_o,
  output logic        busy_o,
  output logic        done_o,
  input  logic        rd_hi_i,
  input  logic        rd_lo_i,
  output logic        stall_o,
  output logic [63:0] hi_o,
  output logic [63:0] lo_o
);

  localparam int LMAX_M = (L_M32 > L_M64) ? L_M32 : L_M64;
  localparam int LMAX_D = (L_D32 > L_D64) ? L_D32 : L_D64;
  localparam int LMAX   = (LMAX_M > LMAX_D) ? LMAX_M : LMAX_D;
  localparam int CNT_W  = $clog2(LMAX);

  mdu_op_t op_in;
  mdu_op_t op_q;

  logic             accept_w;
  logic             busy_w;
  logic             commit_w;
  logic             eng_fin_w;
  logic [CNT_W-1:0] cnt_w;

  logic [XLEN-1:0] a_w, b_w, a_mag, b_mag;
  logic            a_neg, b_neg;

  logic            negq_q, negr_q, dz_q;
  logic [XLEN-1:0] dvd_q;
  logic [XLEN-1:0] hi_q, lo_q;

  logic [2*XLEN-1:0] prod_w;
  logic [XLEN-1:0]   quo_w, rem_w;
  logic              mul_fin_w, div_fin_w;
  logic [2*XLEN-1:0] result_w;

  assign op_in = mdu_op_t'(op_i);

  // Operand preparation: select width, then take magnitudes for the engines
  always_comb begin
    a_w   = widen_opnd(a_i, op_in.wide, op_in.sgn);
    b_w   = widen_opnd(b_i, op_in.wide, op_in.sgn);
    a_neg = op_in.sgn & a_w[XLEN-1];
    b_neg = op_in.sgn & b_w[XLEN-1];
    a_mag = magnitude(a_w, a_neg);
    b_mag = magnitude(b_w, b_neg);
  end

  mdu_ctrl #(
    .L_M32(L_M32), .L_M64(L_M64), .L_D32(L_D32), .L_D64(L_D64), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_in),
    .accept_o (accept_w),
    .busy_o   (busy_w),
    .commit_o (commit_w),
    .done_o   (done_o),
    .cnt_o    (cnt_w)
  );

  mdu_mul_engine #(.DIGIT_W(DIGIT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w & ~op_in.div),
    .wide_i  (op_in.wide),
    .a_mag_i (a_mag),
    .b_mag_i (b_mag),
    .prod_o  (prod_w),
    .fin_o   (mul_fin_w)
  );

  mdu_div_engine u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept_w & op_in.div),
    .wide_i    (op_in.wide),
    .dvd_mag_i (a_mag),
    .dvs_mag_i (b_mag),
    .quo_o     (quo_w),
    .rem_o     (rem_w),
    .fin_o     (div_fin_w)
  );

  assign eng_fin_w = op_q.div ? div_fin_w : mul_fin_w;

  assign result_w = op_q.div
                  ? div_pack(quo_w, rem_w, negq_q, negr_q, op_q.wide, dz_q, dvd_q)
                  : mul_pack(prod_w, negq_q, op_q.wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
      dvd_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (accept_w) begin
        op_q   <= op_in;
        negq_q <= a_neg ^ b_neg;
        negr_q <= a_neg;
        dz_q   <= (b_w == '0);
        dvd_q  <= a_w;
      end
      if (commit_w) begin
        hi_q <= result_w[2*XLEN-1:XLEN];
        lo_q <= result_w[XLEN-1:0];
      end
    end
  end

  assign ready_o = ~busy_w;
  assign busy_o  = busy_w;
  assign stall_o = busy_w & (rd_hi_i | rd_lo_i);
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;

endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
  parameter int CW    = 8,
  parameter int L_M32 = 10,
  parameter int L_M64 = 20,
  parameter int L_D32 = 69,
  parameter int L_D64 = 133
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          ready_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          stall_o,
  input logic [63:0]   hi_o,
  input logic [63:0]   lo_o,
  input logic          commit_w,
  input logic          eng_fin_w,
  input logic [CW-1:0] cnt_w,
  input logic [2:0]    op_q
);

  logic [15:0] busy_len;
  int          exp_lat;

  always_comb begin
    case (op_q[1:0])
      2'b00:   exp_lat = L_M32;
      2'b10:   exp_lat = L_M64;
      2'b01:   exp_lat = L_D32;
      default: exp_lat = L_D64;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_len <= '0;
    else if (!busy_o) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  // R2
  lat_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> (busy_len == 16'(exp_lat - 1)));

  // R2
  engine_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> eng_fin_w);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !commit_w) |=> (cnt_w == $past(cnt_w) - CW'(1)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> ($stable(hi_o) && $stable(lo_o)));

  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !stall_o);

  // R1
  ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && !busy_o));

endmodule

bind mdu_unit mdu_unit_chk #(
  .CW(CNT_W), .L_M32(L_M32), .L_M64(L_M64), .L_D32(L_D32), .L_D64(L_D64)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .stall_o   (stall_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o),
  .commit_w  (commit_w),
  .eng_fin_w (eng_fin_w),
  .cnt_w     (cnt_w),
  .op_q      (op_q)
);

// File: tb/mdu_unit_bench.sv
module mdu_unit_bench;

  localparam logic [2:0] MUL32U = 3'b000, DIV32U = 3'b001, MUL64U = 3'b010, DIV64U = 3'b011;
  localparam logic [2:0] MUL32S = 3'b100, DIV32S = 3'b101, MUL64S = 3'b110, DIV64S = 3'b111;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        rd_hi_i = 1'b0, rd_lo_i = 1'b0;
  logic        ready_o, busy_o, done_o, stall_o;
  logic [63:0] hi_o, lo_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  typedef struct {
    logic [63:0] hi;
    logic [63:0] lo;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdu_unit u_mdu_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .ready_o(ready_o), .busy_o(busy_o), .done_o(done_o),
    .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i), .stall_o(stall_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic int lat_of(input logic [2:0] op);
    if (!op[0]) return op[1] ? 20 : 10;
    return op[1] ? 133 : 69;
  endfunction

  // Reference model written from the requirements with native operators
  function automatic logic [127:0] ref_calc(input logic [2:0] op, input logic [63:0] a,
                                            input logic [63:0] b);
    logic wide, sgn;
    logic [63:0] av, bv, q, r;
    logic [127:0] ax, bx, p;
    wide = op[1];
    sgn  = op[2];
    av = wide ? a : (sgn ? sx(a[31:0]) : {32'b0, a[31:0]});
    bv = wide ? b : (sgn ? sx(b[31:0]) : {32'b0, b[31:0]});
    if (!op[0]) begin
      ax = sgn ? {{64{av[63]}}, av} : {64'b0, av};
      bx = sgn ? {{64{bv[63]}}, bv} : {64'b0, bv};
      p  = ax * bx;
      if (wide) return p;
      return {sx(p[63:32]), sx(p[31:0])};
    end
    if (bv == 64'd0) begin
      q = '1;
      r = av;
    end else if (sgn && bv == '1 && (wide ? (av == MIN64) : (av == sx(32'h8000_0000)))) begin
      q = av;
      r = '0;
    end else if (sgn) begin
      q = $signed(av) / $signed(bv);
      r = $signed(av) % $signed(bv);
    end else begin
      q = av / bv;
      r = av % bv;
    end
    if (wide) return {r, q};
    return {sx(r[31:0]), sx(q[31:0])};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: wait for ready, present one request, push the expected completion
  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    exp_t e;
    logic [127:0] r;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    start_i = 1'b1;
    op_i = op;
    a_i = a;
    b_i = b;
    r = ref_calc(op, a, b);
    e.hi = r[127:64];
    e.lo = r[63:0];
    e.due = cyc + 1 + lat_of(op);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each completion's cycle and value with the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected done", {hi_o, lo_o}, 128'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due && hi_o == e.hi && lo_o == e.lo,
                $sformatf("%s (cycle %0d vs %0d)", e.tag, cyc, e.due),
                {hi_o, lo_o}, {e.hi, e.lo});
        end
      end else if (sb.size() != 0 && cyc >= sb[0].due) begin
        exp_t e;
        e = sb.pop_front();
        check(1'b0, $sformatf("R2 %s missing done at cycle %0d", e.tag, e.due),
              {hi_o, lo_o}, {e.hi, e.lo});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [127:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(ready_o && !busy_o && !done_o && !stall_o, "R10 control outputs",
          {124'd0, ready_o, busy_o, done_o, stall_o}, 128'h8);
    check(hi_o == 0 && lo_o == 0, "R10 result registers", {hi_o, lo_o}, 128'd0);

    // R4 multiply, R8 32-bit handling
    issue(MUL32U, 64'hFFFF_FFFF_0000_0007, 64'h1234_5678_0000_0009, "R8 mul32u ignores upper bits");
    issue(MUL32U, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R8 mul32u sign-extends result");
    issue(MUL32S, 64'h0000_0000_FFFF_FFFD, 64'h0000_0000_0000_1000, "R4 mul32s negative");
    issue(MUL64U, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4 mul64u max");
    issue(MUL64S, 64'hFFFF_FFFF_FFFF_FFF9, 64'h0123_4567_89AB_CDEF, "R4 mul64s mixed sign");
    issue(MUL64S, MIN64, MIN64, "R4 mul64s min*min");
    drain();

    // R5 divide with signs
    issue(DIV32S, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R5 div32s neg dividend");
    issue(DIV32S, 64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFFE, "R5 div32s neg divisor");
    issue(DIV32U, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0010, "R8 div32u zero-extends");
    issue(DIV64U, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0001_2345, "R5 div64u");
    issue(DIV64S, 64'h8000_0000_0000_0011, 64'h0000_0000_0000_0100, "R5 div64s rem sign");
    drain();

    // R6 divide by zero, R7 overflow
    issue(DIV64S, 64'hFFFF_FFFF_FFFF_FF00, 64'd0, "R6 div64s by zero");
    issue(DIV32U, 64'hAAAA_AAAA_8765_4321, 64'hFFFF_FFFF_0000_0000, "R6 div32u by zero");
    issue(DIV64S, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, "R7 div64s min by -1");
    issue(DIV32S, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R7 div32s min by -1");
    drain();

    // R3 refused start and R9 stall during busy
    issue(DIV64U, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0003, "R3 running op survives pokes");
    for (int i = 0; i < 3; i++) begin
      start_i = 1'b1;
      op_i = MUL32U;
      a_i = 64'd5;
      b_i = 64'd5;
      rd_hi_i = (i != 1);
      rd_lo_i = (i == 1);
      #0.5;
      check(stall_o === 1'b1, "R9 stall while busy", {127'd0, stall_o}, 128'd1);
      check(ready_o === 1'b0, "R1 not ready while busy", {127'd0, ready_o}, 128'd0);
      @(negedge clk);
    end
    start_i = 1'b0;
    rd_hi_i = 1'b0;
    rd_lo_i = 1'b0;
    drain();
    repeat (30) @(negedge clk);
    rd_hi_i = 1'b1;
    #0.5;
    check(stall_o === 1'b0, "R9 no stall when idle", {127'd0, stall_o}, 128'd0);
    rd_hi_i = 1'b0;

    // R11 back-to-back: second request lands in the done cycle of the first
    issue(MUL32S, 64'h0000_0000_FFFF_FF00, 64'h0000_0000_0000_0300, "R11 first of pair");
    prev = ref_calc(MUL32S, 64'h0000_0000_FFFF_FF00, 64'h0000_0000_0000_0300);
    issue(DIV32S, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, "R11 second of pair");
    check(busy_o && hi_o == prev[127:64] && lo_o == prev[63:0], "R11 prior result held",
          {hi_o, lo_o}, prev);
    issue(MUL64U, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, "R11 third of chain");
    drain();
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R2 all completions seen", 128'(sb.size()), 128'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule